// File: doc/BRIEF.md
# Four-Lane Single-Precision Reciprocal Estimator

This block returns a fast approximation of 1/x for IEEE-754 single-precision values. A 128-bit source operand holds four 32-bit lanes. In vector mode each lane gets its own independent estimate. In single-lane mode only bits 31:0 are computed, and bits 127:32 of the result are copied from a second 128-bit input that carries the old destination contents. The estimate meets a fixed relative-error budget. It is not correctly rounded and takes no rounding-mode input. It raises no exception flags.

The mantissa estimate starts from a small seed table indexed by the top mantissa bits. A linear-interpolation step between neighbouring table entries then refines it, using the remaining mantissa bits. The exponent is negated around the bias. Special operands bypass the arithmetic:

- Zeros and denormals produce signed infinities.
- Infinities produce signed zeros.
- NaNs come back quiet.
- Operands whose reciprocal would fall below the normal range are flushed to a zero of the same sign.

A request is accepted whenever `in_valid` is high while `in_ready` is high. The result appears, registered, exactly two clock cycles later, and one request can be accepted per cycle.

Top module: `recip_est4`

## Requirements
- R1: For a normal lane operand with biased exponent field 1..252, the result is a normal value with the operand's sign and a relative error of at most 1.5 × 2^-12 against the exact reciprocal. An operand of exactly 1.0 (0x3F800000) returns exactly 1.0.
- R2: A lane operand whose exponent field (bits 30:23) is zero, whether a zero or a denormal, returns an infinity of the same sign: bits 30:0 equal 0x7F800000 and bit 31 is kept.
- R3: A lane operand that is an infinity (exponent field 255, mantissa zero) returns a zero of the same sign.
- R4: A lane operand with exponent field 253 or 254 (magnitude at least 2^126) returns a zero of the same sign. Any operand with exponent field at most 252, including 1.1111111111010b × 2^125 (0x7E7FE800), returns a nonzero normal result.
- R5: A NaN lane operand (exponent field 255, mantissa nonzero) returns the operand with mantissa bit 22 set. A signalling NaN therefore becomes quiet, and a quiet NaN comes back unchanged.
- R6: With `in_scalar` low, each of the four lanes at bits 32k+31:32k is computed from the same bit range of `in_src`, independently of the other lanes.
- R7: With `in_scalar` high, result bits 31:0 are the estimate for `in_src[31:0]`, and result bits 127:32 equal `in_dst[127:32]` of the same request.
- R8: `out_valid` is high exactly two rising edges after each accepted request and low otherwise. Back-to-back requests produce back-to-back results, in order.
- R9: While `rst` is high, `in_ready` is low. After a reset edge, `out_valid` is low. `in_ready` is high whenever `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_src | input | 128 | Four packed single-precision operands |
| in_dst | input | 128 | Old destination; upper 96 bits are passed through in single-lane mode |
| in_scalar | input | 1 | 1 = compute lane 0 only, 0 = compute all four lanes |
| out_valid | output | 1 | Result valid |
| out_result | output | 128 | Packed reciprocal estimates |

## Verification
The bench aims at the seams of the mantissa table. An operand with an all-zero mantissa gives an interpolated value of exactly 2.0, which must carry into the exponent; a design that mishandled that carry would return values off by a factor of two, or with a wrong exponent, for every power of two. It probes both sides of the flush boundary: 0x7E7FE800 must stay normal, while 2^126 and the largest finite value must flush. It also feeds denormals, which a careless decoder would treat as tiny normals, yielding huge finite values instead of infinity. Single-lane requests carry random old destination data, so a lane-select slip shows up as corrupted upper bits. A back-to-back pair catches a pipeline that drops or reorders results.

// File: rtl/recip_pkg.sv
package recip_pkg;

    localparam int WORD_W   = 32;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int EXP_BIAS = 127;
    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

    // seed table geometry
    localparam int IDX_W   = 6;
    localparam int SEG_W   = MAN_W - IDX_W;
    localparam int TBL_N   = (1 << IDX_W) + 1;
    // 2/m held with Q_FRAC fraction bits, range [1,2]
    localparam int Q_FRAC  = MAN_W + 1;
    localparam int Q_W     = Q_FRAC + 2;
    // neighbour difference is below 2^(Q_FRAC+1-IDX_W)
    localparam int DIFF_W  = Q_FRAC + 1 - IDX_W;
    localparam int PROD_W  = DIFF_W + SEG_W;

    // biased result exponent is EXP_RCP - e (+1 on carry)
    localparam int EXP_RCP   = 2 * EXP_BIAS - 1;
    // operands at or above this exponent give sub-normal reciprocals
    localparam int EXP_FLUSH = 2 * EXP_BIAS - 1;

    localparam logic [MAN_W-1:0] QUIET_BIT = MAN_W'(1) << (MAN_W - 1);

    typedef enum logic [2:0] {
        CLS_NORM,
        CLS_ZERO,
        CLS_INF,
        CLS_NAN,
        CLS_TINY
    } opnd_cls_e;

    typedef struct packed {
        logic                sign;
        opnd_cls_e           cls;
        logic [EXP_W-1:0]    expo;
        logic [MAN_W-1:0]    man;
        logic [Q_W-1:0]      base;
        logic [DIFF_W-1:0]   slope;
    } lane_stage_t;

    // round(2^(Q_FRAC+1) / (1 + i/2^IDX_W))
    function automatic logic [Q_W-1:0] seed_at(input int i);
        longint num;
        longint den;
        num = longint'(1) << (Q_FRAC + 1 + IDX_W);
        den = longint'((1 << IDX_W) + i);
        return Q_W'((num + den / 2) / den);
    endfunction

    function automatic opnd_cls_e classify(input logic [WORD_W-1:0] a);
        logic [EXP_W-1:0] e;
        e = a[WORD_W-2 -: EXP_W];
        if (e == '0)
            return CLS_ZERO;
        else if (e == EXP_ALL1)
            return (a[MAN_W-1:0] == '0) ? CLS_INF : CLS_NAN;
        else if (int'(e) >= EXP_FLUSH)
            return CLS_TINY;
        else
            return CLS_NORM;
    endfunction

endpackage

// File: rtl/recip_seed.sv
module recip_seed
    import recip_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [Q_W-1:0]    base,
    output logic [DIFF_W-1:0] slope
);

    logic [Q_W-1:0] tbl [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        assign tbl[g] = seed_at(g);
    end

    logic [IDX_W:0] nxt;
    logic [Q_W-1:0] diff;

    always_comb begin
        nxt   = {1'b0, idx} + (IDX_W+1)'(1);
        base  = tbl[idx];
        diff  = tbl[idx] - tbl[nxt];
        slope = DIFF_W'(diff);
    end

endmodule

// File: rtl/recip_lane.sv
module recip_lane
    import recip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] est
);

    // ---------------- stage 1: decode and seed lookup
    logic [Q_W-1:0]    seed_base;
    logic [DIFF_W-1:0] seed_slope;
    lane_stage_t       s1_d;
    lane_stage_t       s1_q;

    recip_seed u_seed (
        .idx   (opnd[MAN_W-1 -: IDX_W]),
        .base  (seed_base),
        .slope (seed_slope)
    );

    always_comb begin
        s1_d.sign  = opnd[WORD_W-1];
        s1_d.cls   = classify(opnd);
        s1_d.expo  = opnd[WORD_W-2 -: EXP_W];
        s1_d.man   = opnd[MAN_W-1:0];
        s1_d.base  = seed_base;
        s1_d.slope = seed_slope;
    end

    always_ff @(posedge clk) begin
        if (rst)
            s1_q <= '0;
        else if (en)
            s1_q <= s1_d;
    end

    // ---------------- stage 2: interpolate and pack (registered by the top)
    logic [SEG_W-1:0]  frac;
    logic [PROD_W-1:0] prod;
    logic [Q_W-1:0]    corr;
    logic [Q_W-1:0]    q;
    logic              carry;
    logic [EXP_W-1:0]  exp_r;
    logic [MAN_W-1:0]  man_r;

    always_comb begin
        frac  = s1_q.man[SEG_W-1:0];
        prod  = PROD_W'(s1_q.slope) * PROD_W'(frac);
        corr  = Q_W'(prod >> SEG_W);
        q     = s1_q.base - corr;
        carry = q[Q_FRAC+1];
        exp_r = EXP_W'(EXP_RCP) - s1_q.expo + EXP_W'(carry);
        man_r = carry ? '0 : MAN_W'(q >> (Q_FRAC - MAN_W));

        unique case (s1_q.cls)
            CLS_NORM: est = {s1_q.sign, exp_r, man_r};
            CLS_ZERO: est = {s1_q.sign, EXP_ALL1, {MAN_W{1'b0}}};
            CLS_NAN:  est = {s1_q.sign, EXP_ALL1, s1_q.man | QUIET_BIT};
            default:  est = {s1_q.sign, {(WORD_W-1){1'b0}}};
        endcase
    end

endmodule

// File: rtl/recip_est4.sv
module recip_est4
    import recip_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*WORD_W-1:0] in_src,
    input  logic [LANES*WORD_W-1:0] in_dst,
    input  logic                    in_scalar,
    output logic                    out_valid,
    output logic [LANES*WORD_W-1:0] out_result
);

    localparam int VEC_W = LANES * WORD_W;

    logic             in_fire;
    logic             s1_valid;
    logic             s1_scalar;
    logic [VEC_W-1:0] s1_dst;
    logic [VEC_W-1:0] lane_est;
    logic [VEC_W-1:0] res_d;

    assign in_ready = ~rst;
    assign in_fire  = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_scalar <= 1'b0;
            s1_dst    <= '0;
        end else begin
            s1_valid <= in_fire;
            if (in_fire) begin
                s1_scalar <= in_scalar;
                s1_dst    <= in_dst;
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        recip_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .en   (in_fire),
            .opnd (in_src[k*WORD_W +: WORD_W]),
            .est  (lane_est[k*WORD_W +: WORD_W])
        );

        if (k == 0) begin : g_low
            assign res_d[k*WORD_W +: WORD_W] = lane_est[k*WORD_W +: WORD_W];
        end else begin : g_up
            assign res_d[k*WORD_W +: WORD_W] = s1_scalar ? s1_dst[k*WORD_W +: WORD_W]
                                                         : lane_est[k*WORD_W +: WORD_W];
        end

        // R2
        zero_in_inf_chk: assert property (@(posedge clk) disable iff (rst)
            in_fire && (k == 0 || !in_scalar) && in_src[k*WORD_W+30 -: EXP_W] == '0
            |-> ##2 out_result[k*WORD_W+30 -: 31] == 31'h7F80_0000);

        // R3
        inf_in_zero_chk: assert property (@(posedge clk) disable iff (rst)
            in_fire && (k == 0 || !in_scalar) && in_src[k*WORD_W+30 -: 31] == 31'h7F80_0000
            |-> ##2 out_result[k*WORD_W+30 -: 31] == '0);

        // R5
        nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            in_fire && (k == 0 || !in_scalar) && in_src[k*WORD_W+30 -: EXP_W] == EXP_ALL1
            && in_src[k*WORD_W +: MAN_W] != '0
            |-> ##2 out_result[k*WORD_W +: WORD_W]
                    == ($past(in_src[k*WORD_W +: WORD_W], 2) | 32'h0040_0000));

        // R1
        sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
            in_fire && (k == 0 || !in_scalar) && in_src[k*WORD_W+30 -: EXP_W] != EXP_ALL1
            |-> ##2 out_result[k*WORD_W+31] == $past(in_src[k*WORD_W+31], 2));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_result <= res_d;
        end
    end

    // R7
    upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_fire && in_scalar |-> ##2 out_result[VEC_W-1:WORD_W] == $past(in_dst[VEC_W-1:WORD_W], 2));

    // R8
    lat_two_chk: assert property (@(posedge clk) disable iff (rst)
        in_fire |-> ##2 out_valid);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !in_fire |-> ##2 !out_valid);

endmodule

// File: tb/sim_recip_est4.sv
module sim_recip_est4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_src = '0;
    logic [127:0] in_dst = '0;
    logic         in_scalar = 1'b0;
    logic         out_valid;
    logic [127:0] out_result;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    recip_est4 u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_src     (in_src),
        .in_dst     (in_dst),
        .in_scalar  (in_scalar),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic real rel_err(input logic [31:0] a, input logic [31:0] r);
        real m, mr, ratio;
        int  sh;
        m     = 1.0 + real'(a[22:0]) / 8388608.0;
        mr    = 1.0 + real'(r[22:0]) / 8388608.0;
        sh    = int'(r[30:23]) + int'(a[30:23]) - 254;
        ratio = mr * m * (2.0 ** sh);
        return (ratio > 1.0) ? ratio - 1.0 : 1.0 - ratio;
    endfunction

    // check one lane against the requirements
    task automatic check_lane(input logic [31:0] a, input logic [31:0] r);
        logic [7:0]  e;
        logic [31:0] x;
        e = a[30:23];
        if (e == 8'h00) begin
            x = {a[31], 8'hFF, 23'h0};
            chk(r == x, "R2", 128'(r), 128'(x));
        end else if (e == 8'hFF && a[22:0] == '0) begin
            x = {a[31], 31'h0};
            chk(r == x, "R3", 128'(r), 128'(x));
        end else if (e == 8'hFF) begin
            x = a | 32'h0040_0000;
            chk(r == x, "R5", 128'(r), 128'(x));
        end else if (e >= 8'd253) begin
            x = {a[31], 31'h0};
            chk(r == x, "R4", 128'(r), 128'(x));
        end else begin
            chk(r[31] == a[31] && r[30:23] != 8'h00 && r[30:23] != 8'hFF
                && rel_err(a, r) <= 1.5 / 4096.0, "R1", 128'(r), 128'(a));
        end
    endtask

    task automatic run_op(input logic [127:0] src, input logic [127:0] dst, input bit scalar,
                          output logic [127:0] res);
        @(negedge clk);
        in_valid  = 1'b1;
        in_src    = src;
        in_dst    = dst;
        in_scalar = scalar;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R8", 128'(out_valid), 128'(0));
        @(negedge clk);
        chk(out_valid == 1'b1, "R8", 128'(out_valid), 128'(1));
        res = out_result;
    endtask

    task automatic check_vec(input logic [127:0] src, input logic [127:0] dst, input bit scalar,
                             input logic [127:0] res);
        check_lane(src[31:0], res[31:0]);
        if (scalar)
            chk(res[127:32] == dst[127:32], "R7", res, {dst[127:32], res[31:0]});
        else
            for (int k = 1; k < 4; k++) check_lane(src[k*32 +: 32], res[k*32 +: 32]);  // R6
    endtask

    function automatic logic [31:0] rand_word();
        int unsigned sel;
        logic [31:0] w;
        sel = $urandom % 16;
        w   = $urandom;
        case (sel)
            0: w[30:23] = 8'h00;
            1: begin w[30:23] = 8'hFF; w[22:0] = '0; end
            2: begin w[30:23] = 8'hFF; if (w[22:0] == '0) w[0] = 1'b1; end
            3: w[30:23] = 8'(253 + ($urandom % 2));
            4: w[22:0] = '0;
            default: w[30:23] = 8'(1 + ($urandom % 252));
        endcase
        if (sel == 4) w[30:23] = 8'(1 + ($urandom % 252));
        return w;
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] src, dst, res, src_b, res_b;
        int unsigned  seed_dummy;
        seed_dummy = $urandom(32'd2024);

        // reset behaviour (R9)
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R9", 128'(in_ready), 128'(0));
        chk(out_valid == 1'b0, "R9", 128'(out_valid), 128'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", 128'(in_ready), 128'(1));
        chk(out_valid == 1'b0, "R9", 128'(out_valid), 128'(0));

        // directed: zeros, denormals, infinities (R2, R3)
        src = {32'h8000_0001, 32'h0001_2345, 32'h8000_0000, 32'h0000_0000};
        run_op(src, '0, 1'b0, res); check_vec(src, '0, 1'b0, res);
        src = {32'hFF80_0000, 32'h7F80_0000, 32'h7F80_0001, 32'hFFC1_2345};
        run_op(src, '0, 1'b0, res); check_vec(src, '0, 1'b0, res);  // R3, R5
        chk(res[63:32] == 32'h7FC0_0001, "R5", 128'(res[63:32]), 128'(32'h7FC0_0001));
        chk(res[31:0] == 32'hFFC1_2345, "R5", 128'(res[31:0]), 128'(32'hFFC1_2345));

        // directed: exact 1.0, flush boundary (R1, R4)
        src = {32'h7E7F_E800, 32'h7E80_0000, 32'hFF7F_FFFF, 32'h3F80_0000};
        run_op(src, '0, 1'b0, res); check_vec(src, '0, 1'b0, res);
        chk(res[31:0] == 32'h3F80_0000, "R1", 128'(res[31:0]), 128'(32'h3F80_0000));
        chk(res[63:32] == 32'h8000_0000, "R4", 128'(res[63:32]), 128'(32'h8000_0000));
        chk(res[127:96] != 32'h0, "R4", 128'(res[127:96]), 128'(1));
        src = {32'h0080_0000, 32'hBF7F_FFFF, 32'h4000_0000, 32'hC1FF_FFFF};
        run_op(src, '0, 1'b0, res); check_vec(src, '0, 1'b0, res);

        // directed single-lane (R7)
        src = {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h4040_0000};
        dst = 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
        run_op(src, dst, 1'b1, res); check_vec(src, dst, 1'b1, res);

        // back-to-back (R8)
        src   = {32'h3F80_0000, 32'h0, 32'h7F80_0000, 32'h4000_0000};
        src_b = {32'h0, 32'h3F80_0000, 32'h4000_0000, 32'h7F80_0000};
        @(negedge clk);
        in_valid = 1'b1; in_src = src; in_scalar = 1'b0;
        @(negedge clk);
        in_src = src_b;
        @(negedge clk);
        in_valid = 1'b0;
        res = out_result;
        chk(out_valid == 1'b1, "R8", 128'(out_valid), 128'(1));
        check_vec(src, '0, 1'b0, res);
        @(negedge clk);
        res_b = out_result;
        chk(out_valid == 1'b1, "R8", 128'(out_valid), 128'(1));
        check_vec(src_b, '0, 1'b0, res_b);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", 128'(out_valid), 128'(0));

        // constrained random, packed and single-lane (R1..R7)
        for (int i = 0; i < 400; i++) begin
            bit sc;
            sc  = ($urandom % 4) == 0;
            src = {rand_word(), rand_word(), rand_word(), rand_word()};
            dst = {$urandom, $urandom, $urandom, $urandom};
            run_op(src, dst, sc, res);
            check_vec(src, dst, sc, res);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule